// File: doc/BRIEF.md
# Register-Controlled Left Shifter with Condition Flags

This block is one datapath slice of an execution pipeline. It shifts a 32-bit operand left by an amount taken from the low byte of a second register and fills the vacated low bits with zeros. The result goes to a destination write port. A set-flags control bit decides whether the negative, zero, carry and overflow status flags are rewritten. A 4-bit condition code is tested against the incoming flags. A failed test suppresses both the register write and the flag update.

Each operation is offered for one cycle with `in_valid`. The registered result, write enable and next flags appear after the following clock edge. The shift amount covers the full byte range 0 to 255, and each region has its own rule. Zero passes the operand through. Amounts 1 to 31 give a normal shift. Thirty-two clears the result but still produces a carry. Anything larger clears both the result and the carry.

Top module: `shl_flag_unit`

## Requirements
- R1: Outputs are registered. `wr_en` is high in the cycle after a clock edge where `in_valid` was high and the condition passed, and low otherwise. With `in_valid` low, `result_q` and `flags_out` hold their values.
- R2: Only `amt_reg[7:0]` sets the shift amount; `amt_reg[31:8]` has no effect on any output.
- R3: An amount of 0 writes the operand unchanged, and C keeps its incoming value even when `set_flags` is 1.
- R4: For amounts 1 to 31 the result is the operand shifted left with zero fill, and the carry is operand bit (32 − amount).
- R5: An amount of exactly 32 gives result 0 and carry equal to operand bit 0.
- R6: Amounts 33 to 255 give result 0 and carry 0.
- R7: With `set_flags` = 1 and the condition passing, N is result bit 31, Z is 1 exactly when the result is zero, and C is the carry from R3–R6. Flag bit order on `flags_in`/`flags_out` is [3]=N, [2]=Z, [1]=C, [0]=V.
- R8: After a valid operation, V on `flags_out` always equals V on `flags_in`.
- R9: With `set_flags` = 0, a valid operation copies `flags_in` to `flags_out` unchanged.
- R10: The condition codes are 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), and 14 and 15 always pass.
- R11: When the condition fails, `wr_en` stays low, `result_q` holds, and `flags_out` takes `flags_in` unchanged.
- R12: A synchronous reset clears `result_q`, `wr_en` and `flags_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| opnd_a | input | 32 | Value to be shifted |
| amt_reg | input | 32 | Register holding the shift amount in its low byte |
| cond_code | input | 4 | Condition code tested against `flags_in` |
| set_flags | input | 1 | Request to update the status flags |
| flags_in | input | 4 | Current flags, [3]=N [2]=Z [1]=C [0]=V |
| result_q | output | 32 | Registered shift result |
| wr_en | output | 1 | Registered destination write enable |
| flags_out | output | 4 | Registered next flags, same bit order |

## Verification
Every output is one register stage from the inputs. A wrong shift stage, carry tap or condition decode therefore shows up on `result_q`, `flags_out` or `wr_en` at the very next clock. The reference model compares all three outputs after every operation and after every idle cycle. A corrupted held value is caught on the first idle cycle that follows it. Directed sweeps cover the amount boundaries 0, 1, 31, 32, 33 and 255 and every condition code under all 16 flag patterns. These sweeps make sure that a region or decode error cannot hide behind random operands.

// File: rtl/shl_pkg.sv
package shl_pkg;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef enum logic [3:0] {
        CC_EQ = 4'h0, CC_NE = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
        CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
        CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
        CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
    } cc_e;

endpackage

// File: rtl/shl_barrel.sv
module shl_barrel #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [DATA_W-1:0] src,
    input  logic [AMT_W-1:0]  amt,
    output logic [DATA_W-1:0] shifted,
    output logic              carry,
    output logic              amt_zero
);
    // Stage k shifts by 2**k; enough stages reach DATA_W itself
    localparam int STAGES = $clog2(DATA_W) + 1;
    localparam int EXT_W  = DATA_W + 1;

    logic [EXT_W-1:0] stage_v [STAGES+1];
    logic             over;

    assign stage_v[0] = {1'b0, src};

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        assign stage_v[k+1] = amt[k] ? (stage_v[k] << (1 << k)) : stage_v[k];
    end

    // Amounts beyond the operand width flush everything, carry included
    assign over     = (amt > AMT_W'(DATA_W));
    assign amt_zero = (amt == '0);
    assign shifted  = over ? '0 : stage_v[STAGES][DATA_W-1:0];
    assign carry    = over ? 1'b0 : stage_v[STAGES][DATA_W];

endmodule

// File: rtl/shl_cond_check.sv
module shl_cond_check
    import shl_pkg::*;
(
    input  logic [3:0] code,
    input  nzcv_t      fl,
    output logic       pass
);
    logic base;

    always_comb begin
        unique case (code[3:1])
            3'd0:    base = fl.z;
            3'd1:    base = fl.c;
            3'd2:    base = fl.n;
            3'd3:    base = fl.v;
            3'd4:    base = fl.c & ~fl.z;
            3'd5:    base = (fl.n == fl.v);
            3'd6:    base = ~fl.z & (fl.n == fl.v);
            default: base = 1'b1;
        endcase
        // Odd codes invert, except the top pair which both always pass
        pass = (code[3:1] == 3'b111) ? 1'b1 : (base ^ code[0]);
    end

endmodule

// File: rtl/shl_flag_unit.sv
module shl_flag_unit
    import shl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] amt_reg,
    input  logic [3:0]        cond_code,
    input  logic              set_flags,
    input  logic [3:0]        flags_in,
    output logic [DATA_W-1:0] result_q,
    output logic              wr_en,
    output logic [3:0]        flags_out
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              we;
        nzcv_t             fl;
    } state_t;

    state_t            st_d, st_q;
    nzcv_t             cur_fl;
    logic [AMT_W-1:0]  amt;
    logic [DATA_W-1:0] sh_res;
    logic              sh_carry, amt_zero, cond_ok;
    logic              unused_hi;

    assign cur_fl    = nzcv_t'(flags_in);
    assign amt       = amt_reg[AMT_W-1:0];
    assign unused_hi = ^amt_reg[DATA_W-1:AMT_W];

    shl_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_barrel (
        .src      (opnd_a),
        .amt      (amt),
        .shifted  (sh_res),
        .carry    (sh_carry),
        .amt_zero (amt_zero)
    );

    shl_cond_check u_cond (
        .code (cond_code),
        .fl   (cur_fl),
        .pass (cond_ok)
    );

    always_comb begin
        st_d    = st_q;
        st_d.we = 1'b0;
        if (in_valid) begin
            st_d.fl = cur_fl;
            if (cond_ok) begin
                st_d.we  = 1'b1;
                st_d.res = sh_res;
                if (set_flags) begin
                    st_d.fl.n = sh_res[DATA_W-1];
                    st_d.fl.z = (sh_res == '0);
                    st_d.fl.c = amt_zero ? cur_fl.c : sh_carry;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_q  = st_q.res;
    assign wr_en     = st_q.we;
    assign flags_out = st_q.fl;

    // R1: no write without a strobe, and idle cycles hold state
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!wr_en && $stable(result_q) && $stable(flags_out)));

    // R8: overflow flag always follows the incoming value
    p_v_kept_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (flags_out[0] == $past(flags_in[0])));

    // R7: N and Z track the written result
    p_nz_track_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond_ok && set_flags) |=>
            (flags_out[3] == result_q[DATA_W-1] && flags_out[2] == (result_q == '0)));

    // R11: failed condition leaves flags untouched and blocks the write
    p_fail_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !cond_ok) |=>
            (!wr_en && flags_out == $past(flags_in) && $stable(result_q)));

    // R3: a zero amount never alters the carry
    p_zero_amt_c_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && amt_zero) |=> (flags_out[1] == $past(flags_in[1])));

endmodule

// File: tb/tb_shl_flag_unit.sv
module tb_shl_flag_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] amt_reg = '0;
    logic [3:0]  cond_code = '0;
    logic        set_flags = 1'b0;
    logic [3:0]  flags_in = '0;
    logic [31:0] result_q;
    logic        wr_en;
    logic [3:0]  flags_out;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] exp_res = '0;
    logic        exp_we  = 1'b0;
    logic [3:0]  exp_fl  = '0;

    shl_flag_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opnd_a(opnd_a),
        .amt_reg(amt_reg), .cond_code(cond_code), .set_flags(set_flags),
        .flags_in(flags_in), .result_q(result_q), .wr_en(wr_en),
        .flags_out(flags_out)
    );

    always #5 clk = ~clk;

    function automatic bit ref_cond(input int cc, input logic [3:0] f);
        bit n = f[3], z = f[2], c = f[1], v = f[0];
        case (cc)
            0: return z;
            1: return !z;
            2: return c;
            3: return !c;
            4: return n;
            5: return !n;
            6: return v;
            7: return !v;
            8: return c && !z;
            9: return !c || z;
            10: return n == v;
            11: return n != v;
            12: return !z && (n == v);
            13: return z || (n != v);
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] r,
                         input logic w, input logic [3:0] f);
        n_tests++;
        if (result_q !== r) begin
            n_fail++;
            $display("FAIL %s result actual=%h expected=%h", tag, result_q, r);
        end
        n_tests++;
        if (wr_en !== w) begin
            n_fail++;
            $display("FAIL %s wr_en actual=%b expected=%b", tag, wr_en, w);
        end
        n_tests++;
        if (flags_out !== f) begin
            n_fail++;
            $display("FAIL %s flags actual=%b expected=%b", tag, flags_out, f);
        end
    endtask

    task automatic step(input string tag, input bit v, input logic [31:0] a,
                        input logic [31:0] s, input int cc, input bit sf,
                        input logic [3:0] f);
        int amt;
        logic [31:0] r;
        bit cy;
        in_valid  = v;
        opnd_a    = a;
        amt_reg   = s;
        cond_code = 4'(cc);
        set_flags = sf;
        flags_in  = f;
        exp_we    = 1'b0;
        if (v) begin
            exp_fl = f;
            if (ref_cond(cc, f)) begin
                amt = int'(s[7:0]);
                if (amt == 0) begin r = a; cy = f[1]; end
                else if (amt < 32) begin r = a << amt; cy = a[32-amt]; end
                else if (amt == 32) begin r = '0; cy = a[0]; end
                else begin r = '0; cy = 1'b0; end
                exp_we  = 1'b1;
                exp_res = r;
                if (sf) exp_fl = {r[31], (r == 0), cy, f[0]};
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, exp_res, exp_we, exp_fl);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12 reset", 32'h0, 1'b0, 4'h0);
        rst = 1'b0;

        // R3 amount zero: passthrough, carry kept (both values)
        step("R3 zero amt c1", 1, 32'h8000_0001, 32'h0, 14, 1, 4'b0010);
        step("R3 zero amt c0", 1, 32'h0000_0000, 32'h0, 14, 1, 4'b0001);
        // R4 normal shifts
        step("R4 amt1", 1, 32'h8000_0003, 32'd1, 14, 1, 4'b0000);
        step("R4 amt31", 1, 32'h0000_0003, 32'd31, 14, 1, 4'b0000);
        step("R4 amt4", 1, 32'h1234_5678, 32'd4, 14, 1, 4'b1111);
        // R5 amount 32
        step("R5 amt32 c1", 1, 32'h0000_0001, 32'd32, 14, 1, 4'b0000);
        step("R5 amt32 c0", 1, 32'hFFFF_FFFE, 32'd32, 14, 1, 4'b0010);
        // R6 large amounts
        step("R6 amt33", 1, 32'hFFFF_FFFF, 32'd33, 14, 1, 4'b0010);
        step("R6 amt255", 1, 32'hFFFF_FFFF, 32'd255, 14, 1, 4'b1011);
        // R2 upper bits ignored
        step("R2 hi bits", 1, 32'h0000_00F1, 32'hFFFF_FF04, 14, 1, 4'b0000);
        step("R2 hi bits zero", 1, 32'hA5A5_A5A5, 32'h1234_5600, 14, 1, 4'b0100);
        // R7 N and Z
        step("R7 neg", 1, 32'h4000_0000, 32'd1, 14, 1, 4'b0100);
        step("R7 zero", 1, 32'h0000_0000, 32'd3, 14, 1, 4'b1000);
        // R9 no flag update, R8 V kept
        step("R9 s0", 1, 32'h8000_0000, 32'd1, 14, 0, 4'b1010);
        step("R8 v kept", 1, 32'h8000_0000, 32'd1, 15, 1, 4'b0001);
        // R11 failing condition (EQ with Z=0)
        step("R11 fail", 1, 32'h0000_FFFF, 32'd8, 0, 1, 4'b1011);
        // R1 idle cycles hold
        step("R1 idle", 0, 32'hDEAD_BEEF, 32'd2, 14, 1, 4'b1111);
        step("R1 idle2", 0, 32'h0, 32'd40, 3, 0, 4'b0000);

        // R10 every code against every flag pattern
        for (int cc = 0; cc < 16; cc++) begin
            for (int f = 0; f < 16; f++) begin
                step("R10 cond", 1, 32'h0101_0101 * (f + 1), 32'(cc + f), cc, 1, 4'(f));
            end
        end

        // R1/R4/R6 mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] s = $urandom;
            if (i % 2 == 0) s[7:0] = 8'($urandom % 40);
            step("R1 R4 R6 random", ($urandom % 4) != 0, $urandom, s,
                 int'($urandom % 16), 1'($urandom), 4'($urandom));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule